// File: doc/BRIEF.md
# Bit-Change Detector with Selectable Moore or Mealy Core

The block watches a serial stream that presents one bit per clock cycle and raises its output whenever the newest bit differs from the bit before it. Said another way, it flags the two-bit patterns 01 and 10 as they end. The stream has no stall: a bit is taken on every rising clock edge, and the output needs no acknowledgement. Reset is synchronous and clears the bit history, so the first bit after reset is never counted as a change.

Two implementations sit behind one port list. An elaboration parameter picks one of them. The Moore core uses five states and decodes its output from the state alone, so the flag rises one cycle after the bit that caused it and cannot glitch. The Mealy core uses three states that record only the last bit seen. It combines that record with the bit now on the input, so the flag rises in the same cycle as the bit. Because the two cores keep the same interface, a designer can swap one for the other and compare the latency and the output timing.

Top module: `change_detector`

## Requirements
- R1: While `rst` is 1, `change_out` is 0 in both styles, whatever is on `bit_in` and whatever bits came before.
- R2: The first bit taken after reset never raises `change_out`. In the Moore style, `change_out` also stays 0 in the cycle that follows that first bit.
- R3: Mealy style (`STYLE = STYLE_MEALY`): from the second bit after reset onward, `change_out` is 1 in the same cycle exactly when `bit_in` differs from the bit taken at the previous edge.
- R4: Moore style (`STYLE = STYLE_MOORE`): in the cycle after the edge that takes bit n (n at least 2 since reset), `change_out` is 1 exactly when bit n differs from bit n-1.
- R5: In the Moore style, `change_out` depends only on the registered state: changing `bit_in` between clock edges leaves it unchanged.
- R6: With no reset in between, the Moore output in any cycle equals the Mealy output of the previous cycle for the same stream.
- R7: A constant stream keeps `change_out` at 0. An alternating stream keeps it at 1 on every bit after the first one (Mealy), or one cycle later (Moore).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one stream bit is taken per rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the bit history |
| bit_in | input | 1 | Serial stream bit |
| change_out | output | 1 | 1 when the stream changed value (timing set by style) |

## Verification
The bench builds two copies of the block side by side, one with `STYLE_MOORE` and one with `STYLE_MEALY`, and feeds both the same stream. This makes both transition tables reachable, and it lets the bench compare the Moore output directly with the Mealy output of one cycle earlier. Mid-cycle toggles of the input show that the Moore output does not react to them. Resets asserted in the middle of the stream, at points where the Mealy core would otherwise fire, exercise the output gating and the clearing of the history.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

  typedef enum logic {
    STYLE_MOORE = 1'b0,
    STYLE_MEALY = 1'b1
  } detect_style_e;

  // Moore core: history of up to two bits, output decoded per state
  typedef enum logic [2:0] {
    MO_IDLE   = 3'd0,  // nothing seen since reset
    MO_ZERO   = 3'd1,  // last bit 0, no change flagged
    MO_ONE    = 3'd2,  // last bit 1, no change flagged
    MO_RISE   = 3'd3,  // last two bits 0 then 1
    MO_FALL   = 3'd4   // last two bits 1 then 0
  } moore_state_e;

  // Mealy core: only the last bit is remembered
  typedef enum logic [1:0] {
    ME_IDLE = 2'd0,
    ME_ZERO = 2'd1,
    ME_ONE  = 2'd2
  } mealy_state_e;

  function automatic logic moore_flag(moore_state_e s);
    return (s == MO_RISE) || (s == MO_FALL);
  endfunction

endpackage

// File: rtl/chgdet_moore.sv
module chgdet_moore
  import chgdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic hit
);

  moore_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MO_IDLE: state_d = bit_in ? MO_ONE  : MO_ZERO;
      MO_ZERO: state_d = bit_in ? MO_RISE : MO_ZERO;
      MO_ONE:  state_d = bit_in ? MO_ONE  : MO_FALL;
      MO_RISE: state_d = bit_in ? MO_ONE  : MO_FALL;
      MO_FALL: state_d = bit_in ? MO_RISE : MO_ZERO;
      default: state_d = MO_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= MO_IDLE;
    else     state_q <= state_d;
  end

  assign hit = moore_flag(state_q);

endmodule

// File: rtl/chgdet_mealy.sv
module chgdet_mealy
  import chgdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic hit
);

  mealy_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    hit     = 1'b0;
    unique case (state_q)
      ME_IDLE: state_d = bit_in ? ME_ONE : ME_ZERO;
      ME_ZERO: begin
        state_d = bit_in ? ME_ONE : ME_ZERO;
        hit     = bit_in;
      end
      ME_ONE: begin
        state_d = bit_in ? ME_ONE : ME_ZERO;
        hit     = ~bit_in;
      end
      default: state_d = ME_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ME_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/change_detector.sv
module change_detector
  import chgdet_pkg::*;
#(
  parameter detect_style_e STYLE = STYLE_MOORE
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic change_out
);

  logic core_hit;

  generate
    if (STYLE == STYLE_MEALY) begin : g_mealy
      chgdet_mealy u_core (
        .clk    (clk),
        .rst    (rst),
        .bit_in (bit_in),
        .hit    (core_hit)
      );
    end else begin : g_moore
      chgdet_moore u_core (
        .clk    (clk),
        .rst    (rst),
        .bit_in (bit_in),
        .hit    (core_hit)
      );
    end
  endgenerate

  // output forced low for the whole reset window
  assign change_out = core_hit & ~rst;

endmodule

// File: rtl/change_detector_chk.sv
module change_detector_chk
  import chgdet_pkg::*;
#(
  parameter detect_style_e STYLE = STYLE_MOORE
) (
  input logic clk,
  input logic rst,
  input logic bit_in,
  input logic change_out
);

  logic [1:0] seen_q;   // bits taken since reset, saturating at 2
  logic       last1_q;  // bit taken at the previous edge
  logic       last2_q;  // bit taken two edges ago

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q  <= 2'd0;
      last1_q <= 1'b0;
      last2_q <= 1'b0;
    end else begin
      if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
      last1_q <= bit_in;
      last2_q <= last1_q;
    end
  end

  // R1
  always_ff @(posedge clk) begin
    if (rst == 1'b1) begin
      reset_quiet_chk: assert (change_out == 1'b0)
        else $error("R1: output high during reset");
    end
  end

  // R2
  first_bit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q == 2'd0) |-> !change_out);

  generate
    if (STYLE == STYLE_MEALY) begin : g_mealy_chk
      // R3
      mealy_same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q != 2'd0) |-> (change_out == (bit_in != last1_q)));
    end else begin : g_moore_chk
      // R2
      moore_second_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q == 2'd1) |-> !change_out);
      // R4
      moore_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q == 2'd2) |-> (change_out == (last1_q != last2_q)));
    end
  endgenerate

endmodule

bind change_detector change_detector_chk #(.STYLE(STYLE)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bit_in     (bit_in),
  .change_out (change_out)
);

// File: tb/change_detector_tb_top.sv
module change_detector_tb_top;
  import chgdet_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic moore_out, mealy_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench reference state
  bit have_prev = 1'b0;
  bit prev_bit = 1'b0;
  bit last_exp_mealy = 1'b0;
  bit last_act_mealy = 1'b0;
  bit last_rst = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  change_detector #(.STYLE(STYLE_MOORE)) dut_i (
    .clk(clk), .rst(rst), .bit_in(bit_in), .change_out(moore_out)
  );

  change_detector #(.STYLE(STYLE_MEALY)) dut_mealy_i (
    .clk(clk), .rst(rst), .bit_in(bit_in), .change_out(mealy_out)
  );

  function automatic bit ref_change(bit r, bit have, bit prev, bit cur);
    return !r && have && (prev != cur);
  endfunction

  task automatic check(input bit got, input bit exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  // one stream cycle: drive at negedge, sample mid-cycle
  task automatic step(input bit b, input bit r, input string tag);
    bit exp_me, exp_mo, hold_mo;
    @(negedge clk);
    rst = r;
    bit_in = b;
    #1;
    exp_me = ref_change(r, have_prev, prev_bit, b);
    exp_mo = !r && last_exp_mealy;
    if (r) begin
      check(mealy_out, 1'b0, "R1", "mealy in reset");
      check(moore_out, 1'b0, "R1", "moore in reset");
    end else begin
      if (!have_prev) check(mealy_out, exp_me, "R2", "mealy first bit");
      else            check(mealy_out, exp_me, tag, "mealy change");
      check(moore_out, exp_mo, (tag == "R7") ? "R7" : "R4", "moore change");
      if (!last_rst) check(moore_out, last_act_mealy, "R6", "moore vs delayed mealy");
    end
    // R5: toggle input mid-cycle, Moore must not move
    hold_mo = moore_out;
    bit_in = ~b;
    #1;
    check(moore_out, hold_mo, "R5", "moore input-independent");
    bit_in = b;
    #1;
    last_act_mealy = mealy_out;
    last_exp_mealy = exp_me;
    last_rst = r;
    if (r) have_prev = 1'b0;
    else begin
      have_prev = 1'b1;
      prev_bit = b;
    end
  endtask

  initial begin
    int unsigned seed;
    bit b, r;
    seed = 32'h1F2E3D4C;
    void'($urandom(seed));
    // reset with a toggling input
    for (int i = 0; i < 4; i++) step(i[0], 1'b1, "R1");
    // first bit after reset, then constant zeros
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, "R7");
    // alternating stream
    for (int i = 0; i < 8; i++) step(~i[0], 1'b0, "R7");
    // constant ones
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R7");
    // reset where the Mealy core would fire (last bit 1, input 0)
    step(1'b0, 1'b1, "R1");
    step(1'b1, 1'b1, "R1");
    // first bit after reset differs from last bit before reset
    step(1'b0, 1'b0, "R3");
    step(1'b1, 1'b0, "R3");
    step(1'b0, 1'b0, "R3");
    // random stream with sparse resets
    for (int i = 0; i < 3000; i++) begin
      b = 1'($urandom % 2);
      r = (($urandom % 101) == 0);
      step(b, r, "R3");
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule